// File: doc/BRIEF.md
# Queued Two-Wire Handshake Transmitter

This block is the sending end of a parallel processor-to-processor link. A local producer writes fixed-width records into a small internal queue. The block then hands those records one at a time to a receiver over a data bus. The transfer is paced by two wires: an outgoing "record valid" line and an incoming "receiver ready" line. The producer can keep writing while the transmitter waits on a slow receiver, until the queue fills.

A transfer works as follows:

- It can start only while the receiver holds ready high.
- The record is placed on the bus one full cycle before the valid line rises, and it stays fixed while valid is high.
- The receiver completes the transfer by dropping ready after it reads the bus. Only then does the transmitter drop valid and retire the record.
- A new transfer needs ready to be seen high again.

If ready drops in the cycle between bus load and valid rise, the attempt is abandoned and the record stays queued. The ready input is assumed to be synchronous to `clk_i`.

Top module: `hs_queued_tx`

## Requirements
- R1: While `rst_ni` is low, `tx_valid_o` is 0, `tx_data_o` is 0 and `wr_full_o` is 0, and the queue is empty.
- R2: A producer write (`wr_valid_i` high while `wr_full_o` is low) is stored at the next clock edge. `wr_full_o` is high exactly when DEPTH records are held. Writes are accepted in every transfer state.
- R3: A write while `wr_full_o` is high is dropped and never appears on `tx_data_o`.
- R4: A transfer begins only at an edge where the queue is non-empty and `rx_ready_i` is high. Otherwise `tx_valid_o` stays low.
- R5: The head record appears on `tx_data_o` one cycle after the starting edge. `tx_valid_o` rises one cycle after that, provided `rx_ready_i` is still high at that edge.
- R6: `tx_data_o` does not change while `tx_valid_o` is high.
- R7: While `tx_valid_o` is high, it stays high as long as `rx_ready_i` is high. At the first edge where `rx_ready_i` is low, `tx_valid_o` falls and the head record leaves the queue.
- R8: If `rx_ready_i` is low at the edge where `tx_valid_o` would rise, the attempt is abandoned. `tx_valid_o` stays low and the record stays at the head.
- R9: With an empty queue, `tx_valid_o` never rises.
- R10: After a completed or abandoned transfer, the next one starts only at a later edge with `rx_ready_i` high.
- R11: Records reach `tx_data_o` in the order they were accepted, each one exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Producer write strobe |
| wr_data_i | input | DATA_W | Producer record |
| wr_full_o | output | 1 | Queue holds DEPTH records |
| tx_data_o | output | DATA_W | Outgoing record bus |
| tx_valid_o | output | 1 | Record on the bus is available to the receiver |
| rx_ready_i | input | 1 | Receiver ready for data; dropped after reading |

## Verification
Each output has a fixed latency:

- A write shows on `wr_full_o` after one edge.
- A starting edge loads `tx_data_o` after one edge, and `tx_valid_o` rises after a second edge.
- A low `rx_ready_i` seen during valid clears `tx_valid_o` and retires the record after one edge.

The bench steps a behavioural model (a record queue and a phase counter) at every rising edge, using the inputs that are stable there. It compares all three outputs with the model at the following falling edge, so every comparison falls in the cycle the latencies above predict. Inputs change only after that comparison.

// File: rtl/hs_tx_pkg.sv
package hs_tx_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2
  } ph_e;
endpackage

// File: rtl/hs_fifo.sv
module hs_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [AW-1:0]    LAST = AW'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              do_push, do_pop;

  assign full_o  = (cnt_q == FULL_CNT);
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem_q[rd_ptr_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   mem_q[i] <= '0;
      else if (do_push && wr_ptr_q == AW'(i))        mem_q[i] <= push_data_i;
    end
  end
endmodule

// File: rtl/hs_link_fsm.sv
module hs_link_fsm
  import hs_tx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              q_empty_i,
  input  logic [DATA_W-1:0] q_head_i,
  input  logic              rx_ready_i,
  output logic              pop_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_valid_o
);
  ph_e               ph_q, ph_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              valid_q, valid_d;

  always_comb begin
    ph_d    = ph_q;
    data_d  = data_q;
    valid_d = valid_q;
    pop_o   = 1'b0;
    unique case (ph_q)
      PH_IDLE: if (!q_empty_i && rx_ready_i) begin
        data_d = q_head_i;   // bus loaded a cycle ahead of valid
        ph_d   = PH_SETUP;
      end
      PH_SETUP: begin
        if (rx_ready_i) begin
          valid_d = 1'b1;
          ph_d    = PH_ACTIVE;
        end else begin
          ph_d = PH_IDLE;    // receiver withdrew, keep record
        end
      end
      PH_ACTIVE: if (!rx_ready_i) begin
        valid_d = 1'b0;
        pop_o   = 1'b1;
        ph_d    = PH_IDLE;
      end
      default: begin
        ph_d    = PH_IDLE;
        valid_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_IDLE;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      data_q  <= data_d;
      valid_q <= valid_d;
    end
  end

  assign tx_data_o  = data_q;
  assign tx_valid_o = valid_q;
endmodule

// File: rtl/hs_queued_tx.sv
module hs_queued_tx #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_full_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_valid_o,
  input  logic              rx_ready_i
);
  logic [DATA_W-1:0] q_head;
  logic              q_empty, q_pop;

  hs_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (wr_valid_i),
    .push_data_i (wr_data_i),
    .pop_i       (q_pop),
    .head_o      (q_head),
    .empty_o     (q_empty),
    .full_o      (wr_full_o)
  );

  hs_link_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .q_empty_i  (q_empty),
    .q_head_i   (q_head),
    .rx_ready_i (rx_ready_i),
    .pop_o      (q_pop),
    .tx_data_o  (tx_data_o),
    .tx_valid_o (tx_valid_o)
  );
endmodule

// File: rtl/hs_queued_tx_chk.sv
module hs_queued_tx_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_full_o,
  input logic [DATA_W-1:0] tx_data_o,
  input logic              tx_valid_o,
  input logic              rx_ready_i,
  input logic              q_empty
);
  // R4: valid rises only after ready was high at that edge
  a_r4_start_on_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_valid_o) |-> $past(rx_ready_i));
  // R5: bus already settled when valid rises
  a_r5_data_leads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_valid_o) |-> $stable(tx_data_o));
  // R6
  a_r6_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |=> (!tx_valid_o || $stable(tx_data_o)));
  // R7
  a_r7_hold_while_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && rx_ready_i) |=> tx_valid_o);
  a_r7_drop_on_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !rx_ready_i) |=> !tx_valid_o);
  // R2: nothing leaves the queue without a completed transfer
  a_r2_full_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_full_o && !tx_valid_o) |=> wr_full_o);
  // R9
  a_r9_empty_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_empty && !tx_valid_o) |=> !tx_valid_o);
endmodule

bind hs_queued_tx hs_queued_tx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_full_o  (wr_full_o),
  .tx_data_o  (tx_data_o),
  .tx_valid_o (tx_valid_o),
  .rx_ready_i (rx_ready_i),
  .q_empty    (q_empty)
);

// File: tb/hs_queued_tx_test.sv
`timescale 1ns/1ps
module hs_queued_tx_test;
  localparam int DW    = 16;
  localparam int DEPTH = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          rx_ready = 1'b0;
  logic          wr_full, tx_valid;
  logic [DW-1:0] tx_data;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hs_queued_tx #(.DATA_W(DW), .DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .wr_full_o(wr_full), .tx_data_o(tx_data), .tx_valid_o(tx_valid),
    .rx_ready_i(rx_ready));

  // reference model
  logic [DW-1:0] mq[$];
  logic [DW-1:0] m_data;
  logic          m_valid;
  int            m_ph;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete(); m_data = '0; m_valid = 0; m_ph = 0;
    end else begin
      bit acc, pop;
      acc = wr_valid && (mq.size() < DEPTH);
      pop = 0;
      if (m_ph == 0) begin
        if (mq.size() > 0 && rx_ready) begin m_data = mq[0]; m_ph = 1; end
      end else if (m_ph == 1) begin
        if (rx_ready) begin m_valid = 1; m_ph = 2; end else m_ph = 0;
      end else begin
        if (!rx_ready) begin m_valid = 0; pop = 1; m_ph = 0; end
      end
      if (pop) void'(mq.pop_front());
      if (acc) mq.push_back(wr_data);
    end
  end

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(tx_valid == m_valid, "R7 valid", {15'd0, tx_valid}, {15'd0, m_valid});
    chk(tx_data == m_data, "R11 data", tx_data, m_data);
    chk(wr_full == (mq.size() == DEPTH), "R2 full", {15'd0, wr_full}, {15'd0, mq.size() == DEPTH});
  endtask

  task automatic step(input bit wv, input logic [DW-1:0] wd, input bit rdy);
    @(negedge clk);
    compare();
    wr_valid = wv; wr_data = wd; rx_ready = rdy;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] seq;
    seq = 16'h1000;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!tx_valid && !wr_full && tx_data == '0, "R1", tx_data, '0);
    @(negedge clk) rst_n = 1'b1;
    // R4/R9: ready high but empty queue, valid stays low
    for (int i = 0; i < 4; i++) step(0, '0, 1);
    // R2/R3: fill with ready low, overfill ignored
    for (int i = 0; i < 7; i++) begin step(1, seq, 0); seq++; end
    step(0, '0, 0);
    chk(wr_full, "R2 full after fill", {15'd0, wr_full}, 16'd1);
    // R4: no start while ready low
    for (int i = 0; i < 5; i++) step(0, '0, 0);
    chk(!tx_valid, "R4 no start", {15'd0, tx_valid}, 16'd0);
    // R5/R6/R7: a clean transfer, writes continue meanwhile
    step(0, '0, 1);
    for (int i = 0; i < 4; i++) begin step(1, seq, 1); seq++; end
    step(0, '0, 0);
    step(0, '0, 0);
    // R10: ready kept low, no new start
    for (int i = 0; i < 4; i++) step(0, '0, 0);
    // R8: ready pulses one cycle only -> abandoned
    step(0, '0, 1);
    step(0, '0, 0);
    for (int i = 0; i < 3; i++) step(0, '0, 0);
    chk(!tx_valid, "R8 abandoned", {15'd0, tx_valid}, 16'd0);
    // R11: mixed traffic
    for (int i = 0; i < 3000; i++) begin
      bit wv, rd;
      wv = ($urandom % 3) == 0;
      rd = ($urandom % 4) != 0;
      step(wv, seq, rd);
      if (wv) seq++;
    end
    // drain
    for (int i = 0; i < 60; i++) step(0, '0, (i % 4) < 2);
    step(0, '0, 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule